// File: doc/BRIEF.md
# Rotation and Mirror Scan Parameter Calculator

This block turns a description of a framebuffer view into the six values a two-level indexed DMA engine needs to fetch it: the first and last byte addresses touched, the element count per line and the line count, and the signed byte steps applied inside a line and between lines. The view may be turned by 0, 90, 180 or 270 degrees and may be flipped. It may also sit inside a wider virtual line and be subsampled by separate horizontal and vertical scale factors.

A client presents the geometry and pulses `start`. The block latches and normalises the operands, evaluates four pixel offsets on one shared address datapath, and pulses `done`. The results then stay on the outputs until the next accepted start. A flag reports whether the request needs indexed addressing at all, and a second flag reports requests it cannot honour.

Top module: `scan_param_calc`

## Requirements
- R1: A start seen while idle is accepted, and `done` is high for exactly one cycle, five rising edges after the edge that sampled start. A start seen while a calculation is in flight is ignored and yields no extra `done`.
- R2: The byte offset of pixel (x, y) is (y·S·YS + x·XS)·E, where E is 1, 2 or 4 for `elem_code` 0, 1 or 2. `rot_code` 0/1/2/3 means 0/90/180/270 degrees. Top and bottom are base plus the offsets of these corner pixels. Unflipped: 0° (0,0)/(W−1,H−1), 90° (0,H−1)/(W−1,0), 180° (W−1,H−1)/(0,0), 270° (W−1,0)/(0,H−1). Flipped: 0° (W−1,0)/(0,H−1), 90° (W−1,H−1)/(0,0), 180° (0,H−1)/(W−1,0), 270° (0,0)/(W−1,H−1).
- R3: A virtual stride S of zero stands for the visible width W. A scale factor XS or YS of zero stands for 1.
- R4: A step from pixel A to pixel B is off(B) − off(A) − E + 1. The element step keeps its low 16 bits and the frame step its low 32 bits. The element step runs from (1,0) to (0,0) for unflipped 180° and flipped 0°, from (0,0) to (1,0) for unflipped 0° and flipped 180°, from (0,1) to (0,0) for 90°, and from (0,0) to (0,1) for 270°. The frame step runs from the last element of one line to the first element of the next, in the scan order the corners above define.
- R5: The element count is W and the frame count is H at 0° and 180°; the two swap at 90° and 270°.
- R6: With `compat` high, 4-byte elements, 0° and no flip, the bottom address is raised by 2. In every other case `compat` changes nothing.
- R7: `indexed` is high only when rot_code is nonzero, the flip is set, or a nonzero stride or scale factor was supplied.
- R8: `err` is high when elem_code is 3, rot_code is above 3, or a nonzero stride is below W. In that case the other outputs carry no meaning.
- R9: Between a `done` and the next accepted start, every result output holds its value whatever the inputs do.
- R10: After reset, `done`, `err` and `indexed` are low, and all address, count and step outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted when idle |
| base_addr | input | ADDR_W | Byte address of pixel (0,0) |
| width | input | DIM_W | Visible width W in pixels |
| height | input | DIM_W | Visible height H in lines |
| vstride | input | DIM_W | Virtual line length in pixels, 0 = W |
| xscale | input | SCALE_W | Horizontal pixel scale, 0 = 1 |
| yscale | input | SCALE_W | Vertical line scale, 0 = 1 |
| elem_code | input | 2 | Element size: 0=1 B, 1=2 B, 2=4 B, 3 invalid |
| rot_code | input | 3 | 0/1/2/3 = 0/90/180/270 degrees, 4..7 invalid |
| mirror | input | 1 | Flip the scan |
| compat | input | 1 | Legacy bottom-address adjustment enable |
| done | output | 1 | One-cycle completion pulse |
| top_addr | output | ADDR_W | First address fetched |
| bot_addr | output | ADDR_W | Last address fetched |
| elem_cnt | output | DIM_W | Elements per line |
| frame_cnt | output | DIM_W | Lines per frame |
| elem_step | output | EI_W | Signed in-line step |
| frame_step | output | ADDR_W | Signed line-to-line step |
| indexed | output | 1 | Indexed addressing needed |
| err | output | 1 | Request cannot be honoured |

## Verification
All eight rotation and flip pairs are run on non-square views. A swapped corner, a swapped count or a step with the wrong sign therefore gives a different number in each case. Runs with a wide stride and nonzero scales separate the row term from the column term. A view at the largest dimensions drives the 90° element step past 16 bits, so the truncation is checked. The legacy flag is tried in the one case it affects and in two near neighbours, so an over-broad adjustment shows up. Error requests cover each cause alone. Further runs check the hold window, a stray start during a calculation, and an explicit stride equal to W (same addresses as a zero stride, but with indexed mode set).

// File: rtl/scan_calc_pkg.sv
package scan_calc_pkg;
    // fixed signed intermediate width for all offset arithmetic
    localparam int CALC_W = 33;

    typedef logic signed [CALC_W-1:0] calc_t;

    typedef struct packed {
        calc_t x;
        calc_t y;
    } coord_t;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_TOP  = 3'd1,
        PH_BOT  = 3'd2,
        PH_EI   = 3'd3,
        PH_FI   = 3'd4
    } phase_t;

    localparam logic [1:0] ROT_0   = 2'd0;
    localparam logic [1:0] ROT_90  = 2'd1;
    localparam logic [1:0] ROT_180 = 2'd2;
    localparam logic [1:0] ROT_270 = 2'd3;
endpackage

// File: rtl/scan_geom_sel.sv
// Picks corner pixels and step deltas (B - A) for each rotation/flip pair (R2, R4)
module scan_geom_sel
    import scan_calc_pkg::*;
#(
    parameter int DIM_W = 12
) (
    input  logic [1:0]       rot,
    input  logic             mirror,
    input  logic [DIM_W-1:0] w,
    input  logic [DIM_W-1:0] h,
    output coord_t           top_c,
    output coord_t           bot_c,
    output coord_t           ei_c,
    output coord_t           fi_c,
    output logic             swap
);
    calc_t wm1;
    calc_t hm1;
    calc_t one;
    calc_t zero;

    assign wm1  = calc_t'(w) - calc_t'(1);
    assign hm1  = calc_t'(h) - calc_t'(1);
    assign one  = calc_t'(1);
    assign zero = '0;

    function automatic coord_t pt(input calc_t x, input calc_t y);
        coord_t c;
        c.x = x;
        c.y = y;
        return c;
    endfunction

    always_comb begin
        swap  = rot[0];
        top_c = pt(zero, zero);
        bot_c = pt(wm1, hm1);
        ei_c  = pt(one, zero);
        fi_c  = pt(-wm1, one);
        case ({rot, mirror})
            {ROT_0, 1'b0}: begin
                top_c = pt(zero, zero);  bot_c = pt(wm1, hm1);
                ei_c  = pt(one, zero);   fi_c  = pt(-wm1, one);
            end
            {ROT_0, 1'b1}: begin
                top_c = pt(wm1, zero);   bot_c = pt(zero, hm1);
                ei_c  = pt(-one, zero);  fi_c  = pt(wm1, one);
            end
            {ROT_90, 1'b0}: begin
                top_c = pt(zero, hm1);   bot_c = pt(wm1, zero);
                ei_c  = pt(zero, -one);  fi_c  = pt(one, hm1);
            end
            {ROT_90, 1'b1}: begin
                top_c = pt(wm1, hm1);    bot_c = pt(zero, zero);
                ei_c  = pt(zero, -one);  fi_c  = pt(-one, hm1);
            end
            {ROT_180, 1'b0}: begin
                top_c = pt(wm1, hm1);    bot_c = pt(zero, zero);
                ei_c  = pt(-one, zero);  fi_c  = pt(wm1, -one);
            end
            {ROT_180, 1'b1}: begin
                top_c = pt(zero, hm1);   bot_c = pt(wm1, zero);
                ei_c  = pt(one, zero);   fi_c  = pt(-wm1, -one);
            end
            {ROT_270, 1'b0}: begin
                top_c = pt(wm1, zero);   bot_c = pt(zero, hm1);
                ei_c  = pt(zero, one);   fi_c  = pt(-one, -hm1);
            end
            default: begin
                top_c = pt(zero, zero);  bot_c = pt(wm1, hm1);
                ei_c  = pt(zero, one);   fi_c  = pt(one, -hm1);
            end
        endcase
    end
endmodule

// File: rtl/scan_offset_unit.sv
// Shared datapath: byte offset of a signed pixel coordinate (R2, R3)
module scan_offset_unit
    import scan_calc_pkg::*;
#(
    parameter int DIM_W   = 12,
    parameter int SCALE_W = 4
) (
    input  coord_t             pt,
    input  logic [DIM_W-1:0]   vstride,
    input  logic [SCALE_W-1:0] xscale,
    input  logic [SCALE_W-1:0] yscale,
    input  logic [1:0]         esh,
    output calc_t              off
);
    calc_t row_term;
    calc_t col_term;

    assign row_term = pt.y * calc_t'(vstride) * calc_t'(yscale);
    assign col_term = pt.x * calc_t'(xscale);
    assign off      = (row_term + col_term) <<< esh;
endmodule

// File: rtl/scan_param_calc.sv
module scan_param_calc
    import scan_calc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DIM_W   = 12,
    parameter int SCALE_W = 4,
    parameter int EI_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic [DIM_W-1:0]   width,
    input  logic [DIM_W-1:0]   height,
    input  logic [DIM_W-1:0]   vstride,
    input  logic [SCALE_W-1:0] xscale,
    input  logic [SCALE_W-1:0] yscale,
    input  logic [1:0]         elem_code,
    input  logic [2:0]         rot_code,
    input  logic               mirror,
    input  logic               compat,
    output logic               done,
    output logic [ADDR_W-1:0]  top_addr,
    output logic [ADDR_W-1:0]  bot_addr,
    output logic [DIM_W-1:0]   elem_cnt,
    output logic [DIM_W-1:0]   frame_cnt,
    output logic [EI_W-1:0]    elem_step,
    output logic [ADDR_W-1:0]  frame_step,
    output logic               indexed,
    output logic               err
);
    localparam logic [1:0] ESH_WIDE = 2'd2;

    typedef struct packed {
        phase_t             phase;
        logic [ADDR_W-1:0]  base;
        logic [DIM_W-1:0]   w;
        logic [DIM_W-1:0]   h;
        logic [DIM_W-1:0]   vs;
        logic [SCALE_W-1:0] xs;
        logic [SCALE_W-1:0] ys;
        logic [1:0]         esh;
        logic [1:0]         rot;
        logic               mir;
        logic               compat;
        logic               err;
        logic               idx;
        logic               done;
        logic [ADDR_W-1:0]  top;
        logic [ADDR_W-1:0]  bot;
        logic [DIM_W-1:0]   en;
        logic [DIM_W-1:0]   fn;
        logic [EI_W-1:0]    ei;
        logic [ADDR_W-1:0]  fi;
    } state_t;

    state_t st_d;
    state_t st_q;

    coord_t top_c, bot_c, ei_c, fi_c, sel_c;
    logic   swap;
    calc_t  off;
    calc_t  abs_addr;
    calc_t  es_c;
    calc_t  step;
    logic   bot_fix;
    logic   busy;

    scan_geom_sel #(.DIM_W(DIM_W)) u_geom (
        .rot    (st_q.rot),
        .mirror (st_q.mir),
        .w      (st_q.w),
        .h      (st_q.h),
        .top_c  (top_c),
        .bot_c  (bot_c),
        .ei_c   (ei_c),
        .fi_c   (fi_c),
        .swap   (swap)
    );

    // one coordinate per phase goes through the shared offset datapath
    always_comb begin
        case (st_q.phase)
            PH_TOP:  sel_c = top_c;
            PH_BOT:  sel_c = bot_c;
            PH_EI:   sel_c = ei_c;
            default: sel_c = fi_c;
        endcase
    end

    scan_offset_unit #(.DIM_W(DIM_W), .SCALE_W(SCALE_W)) u_off (
        .pt      (sel_c),
        .vstride (st_q.vs),
        .xscale  (st_q.xs),
        .yscale  (st_q.ys),
        .esh     (st_q.esh),
        .off     (off)
    );

    assign busy     = (st_q.phase != PH_IDLE);
    assign abs_addr = calc_t'(st_q.base) + off;
    assign es_c     = calc_t'(1) <<< st_q.esh;
    assign step     = off - es_c + calc_t'(1);
    // legacy adjustment: wide elements, no rotation, no flip (R6)
    assign bot_fix  = st_q.compat && (st_q.esh == ESH_WIDE) &&
                      (st_q.rot == ROT_0) && !st_q.mir;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.base   = base_addr;
                    st_d.w      = width;
                    st_d.h      = height;
                    st_d.vs     = (vstride == '0) ? width : vstride;          // R3
                    st_d.xs     = (xscale == '0) ? SCALE_W'(1) : xscale;     // R3
                    st_d.ys     = (yscale == '0) ? SCALE_W'(1) : yscale;     // R3
                    st_d.esh    = elem_code;
                    st_d.rot    = rot_code[1:0];
                    st_d.mir    = mirror;
                    st_d.compat = compat;
                    st_d.err    = (elem_code == 2'd3) || (rot_code > 3'd3) ||
                                  ((vstride != '0) && (vstride < width));    // R8
                    st_d.idx    = (rot_code != '0) || mirror || (vstride != '0) ||
                                  (xscale != '0) || (yscale != '0);          // R7
                    st_d.phase  = PH_TOP;
                end
            end
            PH_TOP: begin
                st_d.top   = ADDR_W'(abs_addr);
                st_d.phase = PH_BOT;
            end
            PH_BOT: begin
                st_d.bot   = ADDR_W'(abs_addr + (bot_fix ? calc_t'(2) : calc_t'(0)));
                st_d.phase = PH_EI;
            end
            PH_EI: begin
                st_d.ei    = EI_W'(step);                                    // R4
                st_d.phase = PH_FI;
            end
            PH_FI: begin
                st_d.fi    = ADDR_W'(step);                                  // R4
                st_d.en    = swap ? st_q.h : st_q.w;                         // R5
                st_d.fn    = swap ? st_q.w : st_q.h;
                st_d.done  = 1'b1;                                           // R1
                st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;                                              // R10
        else        st_q <= st_d;
    end

    assign done       = st_q.done;
    assign top_addr   = st_q.top;
    assign bot_addr   = st_q.bot;
    assign elem_cnt   = st_q.en;
    assign frame_cnt  = st_q.fn;
    assign elem_step  = st_q.ei;
    assign frame_step = st_q.fi;
    assign indexed    = st_q.idx;
    assign err        = st_q.err;
endmodule

// File: rtl/scan_param_chk.sv
module scan_param_chk #(
    parameter int ADDR_W  = 32,
    parameter int DIM_W   = 12,
    parameter int SCALE_W = 4,
    parameter int EI_W    = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic [DIM_W-1:0]   width,
    input logic [DIM_W-1:0]   height,
    input logic [DIM_W-1:0]   vstride,
    input logic [SCALE_W-1:0] xscale,
    input logic [SCALE_W-1:0] yscale,
    input logic [1:0]         elem_code,
    input logic [2:0]         rot_code,
    input logic               mirror,
    input logic               done,
    input logic [ADDR_W-1:0]  top_addr,
    input logic [ADDR_W-1:0]  bot_addr,
    input logic [DIM_W-1:0]   elem_cnt,
    input logic [DIM_W-1:0]   frame_cnt,
    input logic [EI_W-1:0]    elem_step,
    input logic [ADDR_W-1:0]  frame_step,
    input logic               indexed,
    input logic               err
);
    logic [DIM_W-1:0] cap_w, cap_h;
    logic             cap_bad, cap_idx, cap_swap;
    logic             held;
    logic             accept;

    assign accept = start && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_w    <= '0;
            cap_h    <= '0;
            cap_bad  <= 1'b0;
            cap_idx  <= 1'b0;
            cap_swap <= 1'b0;
            held     <= 1'b0;
        end else begin
            if (accept) begin
                cap_w    <= width;
                cap_h    <= height;
                cap_swap <= rot_code[0];
                cap_bad  <= (elem_code == 2'd3) || (rot_code > 3'd3) ||
                            ((vstride != '0) && (vstride < width));
                cap_idx  <= (rot_code != 3'd0) || mirror || (|vstride) ||
                            (|xscale) || (|yscale);
            end
            if (accept)    held <= 1'b0;
            else if (done) held <= 1'b1;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                     // R1
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ##5 done);                                                // R1
    AST_COUNT_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cap_bad) |-> (elem_cnt == (cap_swap ? cap_h : cap_w)) &&
                               (frame_cnt == (cap_swap ? cap_w : cap_h)));   // R5
    AST_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err == cap_bad));                                          // R8
    AST_INDEXED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (indexed == cap_idx));                                      // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !start) |=> ($stable(top_addr) && $stable(bot_addr) &&
                              $stable(elem_cnt) && $stable(frame_cnt) &&
                              $stable(elem_step) && $stable(frame_step) &&
                              $stable(indexed) && $stable(err)));            // R9
endmodule

bind scan_param_calc scan_param_chk #(
    .ADDR_W(ADDR_W), .DIM_W(DIM_W), .SCALE_W(SCALE_W), .EI_W(EI_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .width(width), .height(height), .vstride(vstride),
    .xscale(xscale), .yscale(yscale), .elem_code(elem_code),
    .rot_code(rot_code), .mirror(mirror), .done(done),
    .top_addr(top_addr), .bot_addr(bot_addr), .elem_cnt(elem_cnt),
    .frame_cnt(frame_cnt), .elem_step(elem_step), .frame_step(frame_step),
    .indexed(indexed), .err(err)
);

// File: tb/sim_scan_param_calc.sv
`timescale 1ns/1ps
module sim_scan_param_calc;
    localparam int ADDR_W = 32, DIM_W = 12, SCALE_W = 4, EI_W = 16;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic [DIM_W-1:0] width = '0, height = '0, vstride = '0;
    logic [SCALE_W-1:0] xscale = '0, yscale = '0;
    logic [1:0] elem_code = '0;
    logic [2:0] rot_code = '0;
    logic mirror = 1'b0, compat = 1'b0;
    logic done, indexed, err;
    logic [ADDR_W-1:0] top_addr, bot_addr, frame_step;
    logic [DIM_W-1:0] elem_cnt, frame_cnt;
    logic [EI_W-1:0] elem_step;

    always #2.5 clk = ~clk;

    scan_param_calc #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .SCALE_W(SCALE_W), .EI_W(EI_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .width(width), .height(height), .vstride(vstride), .xscale(xscale),
        .yscale(yscale), .elem_code(elem_code), .rot_code(rot_code),
        .mirror(mirror), .compat(compat), .done(done), .top_addr(top_addr),
        .bot_addr(bot_addr), .elem_cnt(elem_cnt), .frame_cnt(frame_cnt),
        .elem_step(elem_step), .frame_step(frame_step), .indexed(indexed), .err(err)
    );

    typedef struct {
        logic [31:0] base;
        int w, h, vs, xs, ys, elem, rot;
        bit mir, compat;
        string tag;
    } stim_t;

    typedef struct {
        logic [31:0] top, bot, fi;
        logic [15:0] ei;
        int en, fn, start_cyc;
        bit idx, err, full;
        string tag;
    } exp_t;

    exp_t q[$];
    int n_chk = 0, n_bad = 0, cyc = 0, n_done = 0, n_push = 0;
    logic [31:0] last_top, last_bot, last_fi;
    logic [15:0] last_ei;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic longint pix(longint x, longint y, longint vs, longint xs,
                                   longint ys, longint es);
        return (y * vs * ys + x * xs) * es;
    endfunction

    // reference built from the corner and step table in the requirements
    function automatic exp_t model(stim_t s);
        exp_t e;
        longint es, vs, xs, ys, w1, h1;
        longint p[12];
        longint off_t, off_b, ei, fi;
        e.tag = s.tag; e.top = '0; e.bot = '0; e.fi = '0; e.ei = '0;
        e.en = 0; e.fn = 0; e.start_cyc = 0;
        e.err = (s.elem == 3) || (s.rot > 3) || (s.vs != 0 && s.vs < s.w);
        e.idx = (s.rot != 0) || s.mir || (s.vs != 0) || (s.xs != 0) || (s.ys != 0);
        e.full = !e.err;
        if (e.err) return e;
        es = longint'(1) << s.elem;
        vs = (s.vs == 0) ? s.w : s.vs;
        xs = (s.xs == 0) ? 1 : s.xs;
        ys = (s.ys == 0) ? 1 : s.ys;
        w1 = s.w - 1; h1 = s.h - 1;
        // top(x,y) bottom(x,y) EI A->B  FI A->B
        case (s.rot * 2 + int'(s.mir))
            0: p = '{0, 0,   w1, h1, 0, 0, 1, 0,   w1, 0, 0, 1};
            1: p = '{w1, 0,  0, h1,  1, 0, 0, 0,   0, 0, w1, 1};
            2: p = '{0, h1,  w1, 0,  0, 1, 0, 0,   0, 0, 1, h1};
            3: p = '{w1, h1, 0, 0,   0, 1, 0, 0,   1, 0, 0, h1};
            4: p = '{w1, h1, 0, 0,   1, 0, 0, 0,   0, 1, w1, 0};
            5: p = '{0, h1,  w1, 0,  0, 0, 1, 0,   w1, 1, 0, 0};
            6: p = '{w1, 0,  0, h1,  0, 0, 0, 1,   1, h1, 0, 0};
            default: p = '{0, 0, w1, h1, 0, 0, 0, 1, 0, h1, 1, 0};
        endcase
        off_t = pix(p[0], p[1], vs, xs, ys, es);
        off_b = pix(p[2], p[3], vs, xs, ys, es);
        ei = pix(p[6], p[7], vs, xs, ys, es) - pix(p[4], p[5], vs, xs, ys, es) - es + 1;
        fi = pix(p[10], p[11], vs, xs, ys, es) - pix(p[8], p[9], vs, xs, ys, es) - es + 1;
        e.top = 32'(longint'(s.base) + off_t);
        e.bot = 32'(longint'(s.base) + off_b +
                    ((s.compat && s.elem == 2 && s.rot == 0 && !s.mir) ? 2 : 0));
        e.ei = 16'(ei);
        e.fi = 32'(fi);
        e.en = (s.rot % 2 == 1) ? s.h : s.w;
        e.fn = (s.rot % 2 == 1) ? s.w : s.h;
        return e;
    endfunction

    task automatic put(stim_t s);
        base_addr = s.base; width = DIM_W'(s.w); height = DIM_W'(s.h);
        vstride = DIM_W'(s.vs); xscale = SCALE_W'(s.xs); yscale = SCALE_W'(s.ys);
        elem_code = 2'(s.elem); rot_code = 3'(s.rot); mirror = s.mir; compat = s.compat;
    endtask

    // driver: push expectation, pulse start, optionally a stray start while busy
    task automatic run(stim_t s, bit stray);
        exp_t e;
        stim_t o;
        e = model(s);
        @(negedge clk);
        put(s);
        start = 1'b1;
        e.start_cyc = cyc;
        q.push_back(e);
        n_push++;
        @(negedge clk);
        start = 1'b0;
        if (stray) begin
            o = s; o.w = 3; o.h = 2; o.rot = (s.rot + 1) % 4; o.base = 32'h55;
            @(negedge clk);
            put(o);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        repeat (7) @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            exp_t e;
            n_done++;
            if (q.size() == 0) begin
                chk(1'b0, "R1", "unexpected done", 1, 0);
            end else begin
                e = q.pop_front();
                chk(cyc - e.start_cyc == 5, "R1", {e.tag, " latency"}, cyc - e.start_cyc, 5);
                chk(err == e.err, "R8", {e.tag, " err"}, err, e.err);
                if (e.full) begin
                    chk(indexed == e.idx, "R7", {e.tag, " indexed"}, indexed, e.idx);
                    chk(top_addr == e.top, "R2", {e.tag, " top"}, top_addr, e.top);
                    chk(bot_addr == e.bot, "R2 R6", {e.tag, " bottom"}, bot_addr, e.bot);
                    chk(elem_step == e.ei, "R4", {e.tag, " elem step"}, elem_step, e.ei);
                    chk(frame_step == e.fi, "R4", {e.tag, " frame step"}, frame_step, e.fi);
                    chk(int'(elem_cnt) == e.en, "R5", {e.tag, " elem cnt"}, elem_cnt, e.en);
                    chk(int'(frame_cnt) == e.fn, "R5", {e.tag, " frame cnt"}, frame_cnt, e.fn);
                end
            end
            last_top = top_addr; last_bot = bot_addr; last_ei = elem_step; last_fi = frame_step;
        end
    end

    function automatic stim_t mk(logic [31:0] base, int w, int h, int vs, int xs, int ys,
                                 int elem, int rot, bit mir, bit cmp, string tag);
        stim_t s;
        s.base = base; s.w = w; s.h = h; s.vs = vs; s.xs = xs; s.ys = ys;
        s.elem = elem; s.rot = rot; s.mir = mir; s.compat = cmp; s.tag = tag;
        return s;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(done == 1'b0, "R10", "done", done, 0);
        chk(err == 1'b0 && indexed == 1'b0, "R10", "flags", {err, indexed}, 0);
        chk(top_addr == '0 && bot_addr == '0, "R10", "addresses", top_addr | bot_addr, 0);
        chk(elem_step == '0 && frame_step == '0 && elem_cnt == '0 && frame_cnt == '0,
            "R10", "steps and counts", frame_step, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R4 R5: all eight rotation/flip pairs on a non-square view
        run(mk(32'h1000, 8, 4, 0, 0, 0, 1, 0, 0, 0, "rot0"), 0);
        run(mk(32'h2000, 5, 3, 8, 0, 0, 2, 0, 1, 0, "rot0 flip"), 0);
        run(mk(32'h3000, 6, 5, 10, 2, 3, 0, 1, 0, 0, "rot90"), 0);
        run(mk(32'h3000, 6, 5, 10, 2, 3, 1, 1, 1, 0, "rot90 flip"), 0);
        run(mk(32'h4000, 7, 3, 9, 0, 2, 1, 2, 0, 0, "rot180"), 0);
        run(mk(32'h4000, 7, 3, 9, 3, 0, 2, 2, 1, 0, "rot180 flip"), 0);
        run(mk(32'h5000, 4, 9, 0, 0, 0, 1, 3, 0, 0, "rot270"), 0);
        run(mk(32'h5000, 4, 9, 12, 2, 2, 0, 3, 1, 0, "rot270 flip"), 0);
        // R3 explicit stride equal to width gives the same addresses, indexed set
        run(mk(32'h1000, 8, 4, 8, 1, 1, 1, 0, 0, 0, "R3 explicit defaults"), 0);
        // R6 legacy adjustment and its neighbours
        run(mk(32'h6000, 10, 6, 0, 0, 0, 2, 0, 0, 1, "R6 compat wide"), 0);
        run(mk(32'h6000, 10, 6, 0, 0, 0, 1, 0, 0, 1, "R6 compat narrow"), 0);
        run(mk(32'h6000, 10, 6, 0, 0, 0, 2, 0, 1, 1, "R6 compat flip"), 0);
        // R4 truncation on large views and wrap of the address space
        run(mk(32'hFFFF_F000, 4095, 4095, 4095, 15, 15, 2, 1, 0, 0, "R4 big rot90"), 0);
        run(mk(32'h8000_0000, 4095, 4095, 0, 15, 15, 2, 2, 1, 0, "R4 big rot180 flip"), 0);
        // R8 each error cause
        run(mk(32'h0, 8, 4, 5, 0, 0, 1, 0, 0, 0, "R8 short stride"), 0);
        run(mk(32'h0, 8, 4, 0, 0, 0, 3, 0, 0, 0, "R8 bad elem"), 0);
        run(mk(32'h0, 8, 4, 0, 0, 0, 1, 5, 0, 0, "R8 bad rot"), 0);
        // R1 stray start while busy is ignored
        run(mk(32'h7000, 9, 7, 11, 0, 0, 1, 2, 0, 0, "R1 stray start"), 1);

        // R9 outputs hold while inputs move without start
        put(mk(32'hABC0, 3, 3, 0, 1, 1, 0, 1, 1, 0, "noise"));
        repeat (6) @(negedge clk);
        chk(top_addr == last_top && bot_addr == last_bot, "R9", "addresses held",
            top_addr, last_top);
        chk(elem_step == last_ei && frame_step == last_fi, "R9", "steps held",
            frame_step, last_fi);
        chk(done == 1'b0, "R9", "no done without start", done, 0);

        repeat (4) @(negedge clk);
        chk(n_done == n_push, "R1", "done count", n_done, n_push);
        chk(q.size() == 0, "R1", "pending results", q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule